// File: doc/BRIEF.md
# Branch Target Prediction Table

This block is a small fully associative branch target table for the second fetch stage of a deep pipeline. In every cycle it compares the current fetch PC against all valid entries at once. It returns a predicted next PC and a taken flag, which the next-PC selection logic uses.

Two stages later, the first execute stage sends a resolution. This carries the branch PC, its real target, its real direction, and the prediction that was made for it. The table updates its 2-bit per-entry predictor from the resolution. It inserts a newly seen taken branch into a slot chosen by a round-robin pointer. When the earlier prediction was wrong, it raises a flush request together with the PC the fetch unit should restart from. Each misprediction therefore costs the two fetch-side cycles that get flushed.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves every entry invalid, so the first lookup after reset predicts not taken with `pred_npc` = `fetch_pc` + 4.
- R2: A fetch PC that matches no valid entry yields `pred_taken` = 0 and `pred_npc` = `fetch_pc` + 4.
- R3: A fetch PC that matches a valid entry yields `pred_taken` = bit 1 of that entry's 2-bit state. The state encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. `pred_npc` is the stored target when taken and `fetch_pc` + 4 otherwise.
- R4: A valid taken resolution whose PC misses in the table allocates the slot at the round-robin pointer. The first allocation after reset uses slot 0. The new entry starts weak not-taken, is stepped once by the taken outcome, and so predicts taken to the resolved target from the next cycle.
- R5: A valid not-taken resolution whose PC misses in the table allocates nothing, and the round-robin pointer does not move.
- R6: A resolution that hits moves the entry's state one step toward taken on a taken outcome and one step toward not-taken otherwise. The state saturates at 11 and at 00.
- R7: A taken resolution that hits replaces the entry's stored target with the resolved target.
- R8: `flush` is high in the cycle of a valid resolution whose predicted direction differs from the real one. `redirect_pc` then equals `res_target` if the branch was taken and `res_pc` + 4 if not.
- R9: `flush` is high when a branch predicted taken and actually taken had a predicted target different from `res_target`. `redirect_pc` then equals `res_target`.
- R10: `flush` stays low when the prediction was correct in both direction and target, and whenever `res_valid` is low.
- R11: The round-robin pointer wraps after the last slot. Once all slots are filled, the next allocation evicts the oldest entry, and the other entries keep predicting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | PC_W | PC presented by the next-PC logic |
| pred_npc | output | PC_W | Predicted next fetch PC |
| pred_taken | output | 1 | Prediction is taken |
| res_valid | input | 1 | A branch resolution is present this cycle |
| res_pc | input | PC_W | PC of the resolved branch |
| res_target | input | PC_W | Real target of the resolved branch |
| res_taken | input | 1 | Real direction of the resolved branch |
| res_pred_taken | input | 1 | Direction that was predicted for it |
| res_pred_target | input | PC_W | Next PC that was predicted for it |
| flush | output | 1 | Misprediction: clear the fetch-side registers |
| redirect_pc | output | PC_W | Correct PC to restart fetch from |

## Verification
The bench builds the table with four entries and a 32-bit PC. With only four slots, a fifth distinct taken branch forces the pointer to wrap and evict the first entry within a few cycles, and the run checks both the eviction and the survival of the other entries. One branch is driven through both saturation ends of its counter, through a target change, and through every flush cause. Not-taken misses are placed before the allocation run, so a wrongly advanced pointer would evict the wrong entry and be caught.

// File: rtl/btb_pkg.sv
package btb_pkg;
    // 2-bit direction predictor encoding; bit 1 is the predicted direction
    localparam logic [1:0] BST_SNT = 2'b00;
    localparam logic [1:0] BST_WNT = 2'b01;
    localparam logic [1:0] BST_WT  = 2'b10;
    localparam logic [1:0] BST_ST  = 2'b11;
endpackage

// File: rtl/btb_lookup.sv
module btb_lookup #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [PC_W-1:0]               key,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][PC_W-1:0]  tags,
    output logic [ENTRIES-1:0]            match,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    // one comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    assign hit = |match;

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/btb_ctr_step.sv
module btb_ctr_step (
    input  logic [1:0] cur,
    input  logic       taken,
    output logic [1:0] nxt
);
    import btb_pkg::*;
    always_comb begin
        nxt = cur;
        if (taken && cur != BST_ST)       nxt = cur + 2'd1;
        else if (!taken && cur != BST_SNT) nxt = cur - 2'd1;
    end
endmodule

// File: rtl/btb_rr_ptr.sv
module btb_rr_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    a_r11_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        adv && ptr_q == LAST |=> ptr_q == '0);
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ptr_q == $past(ptr_q));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int PC_W       = 32,
    parameter int ENTRIES    = 16,
    parameter int INSN_BYTES = 4,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] pred_npc,
    output logic            pred_taken,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_taken,
    input  logic            res_pred_taken,
    input  logic [PC_W-1:0] res_pred_target,
    output logic            flush,
    output logic [PC_W-1:0] redirect_pc
);
    import btb_pkg::*;

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    typedef struct packed {
        logic [ENTRIES-1:0]           valid;
        logic [ENTRIES-1:0][PC_W-1:0] tag;
        logic [ENTRIES-1:0][PC_W-1:0] tgt;
        logic [ENTRIES-1:0][1:0]      st;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [ENTRIES-1:0] f_match, r_match;
    logic               f_hit, r_hit;
    logic [IDX_W-1:0]   f_idx, r_idx, ptr, upd_idx;
    logic [1:0]         cur_st, nxt_st;
    logic               alloc, do_write;

    btb_lookup #(.PC_W(PC_W), .ENTRIES(ENTRIES)) i_fetch_lookup (
        .key(fetch_pc), .valid(tbl_q.valid), .tags(tbl_q.tag),
        .match(f_match), .hit(f_hit), .idx(f_idx));

    btb_lookup #(.PC_W(PC_W), .ENTRIES(ENTRIES)) i_res_lookup (
        .key(res_pc), .valid(tbl_q.valid), .tags(tbl_q.tag),
        .match(r_match), .hit(r_hit), .idx(r_idx));

    btb_rr_ptr #(.ENTRIES(ENTRIES)) i_ptr (
        .clk(clk), .rst(rst), .adv(alloc), .ptr(ptr));

    btb_ctr_step i_ctr (.cur(cur_st), .taken(res_taken), .nxt(nxt_st));

    // prediction path
    always_comb begin
        pred_taken = f_hit && tbl_q.st[f_idx][1];
        pred_npc   = pred_taken ? tbl_q.tgt[f_idx] : fetch_pc + STEP;
    end

    // resolution path
    always_comb begin
        alloc    = res_valid && !r_hit && res_taken;
        do_write = res_valid && (r_hit || res_taken);
        upd_idx  = r_hit ? r_idx : ptr;
        cur_st   = r_hit ? tbl_q.st[r_idx] : BST_WNT;

        tbl_d = tbl_q;
        if (do_write) begin
            tbl_d.valid[upd_idx] = 1'b1;
            tbl_d.tag[upd_idx]   = res_pc;
            tbl_d.st[upd_idx]    = nxt_st;
            if (res_taken) tbl_d.tgt[upd_idx] = res_target;
        end

        flush = res_valid && ((res_pred_taken != res_taken) ||
                              (res_pred_taken && res_pred_target != res_target));
        redirect_pc = res_taken ? res_target : res_pc + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= '0;
        else     tbl_q <= tbl_d;
    end

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_taken);
    a_r4_alloc_lands: assert property (@(posedge clk) disable iff (rst)
        alloc |=> tbl_q.valid[$past(ptr)] && tbl_q.tag[$past(ptr)] == $past(res_pc)
                  && tbl_q.st[$past(ptr)] == BST_WT);
    a_r6_sat_top: assert property (@(posedge clk) disable iff (rst)
        res_valid && r_hit && res_taken && tbl_q.st[r_idx] == BST_ST
        |=> tbl_q.st[$past(r_idx)] == BST_ST);
    a_r6_sat_bottom: assert property (@(posedge clk) disable iff (rst)
        res_valid && r_hit && !res_taken && tbl_q.st[r_idx] == BST_SNT
        |=> tbl_q.st[$past(r_idx)] == BST_SNT);
    a_r10_flush_needs_valid: assert property (@(posedge clk) disable iff (rst)
        flush |-> res_valid);
    a_r11_unique_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(f_match) && $onehot0(r_match));
endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] fetch_pc = '0;
    logic [PW-1:0] pred_npc;
    logic          pred_taken;
    logic          res_valid = 1'b0;
    logic [PW-1:0] res_pc = '0, res_target = '0, res_pred_target = '0;
    logic          res_taken = 1'b0, res_pred_taken = 1'b0;
    logic          flush;
    logic [PW-1:0] redirect_pc;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        bit            is_res;
        logic [PW-1:0] npc;
        logic          tk;
        logic          fl;
        logic [PW-1:0] rd;
        bit            chk_rd;
        string         req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    btb_predictor #(.PC_W(PW), .ENTRIES(4)) i_btb_predictor (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_npc(pred_npc),
        .pred_taken(pred_taken), .res_valid(res_valid), .res_pc(res_pc),
        .res_target(res_target), .res_taken(res_taken),
        .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
        .flush(flush), .redirect_pc(redirect_pc));

    // monitor: compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (!e.is_res) begin
                if (pred_taken !== e.tk || pred_npc !== e.npc) begin
                    n_fail++;
                    $display("FAIL %s: taken=%0b npc=%h expected taken=%0b npc=%h",
                             e.req, pred_taken, pred_npc, e.tk, e.npc);
                end
            end else begin
                if (flush !== e.fl || (e.chk_rd && redirect_pc !== e.rd)) begin
                    n_fail++;
                    $display("FAIL %s: flush=%0b redirect=%h expected flush=%0b redirect=%h",
                             e.req, flush, redirect_pc, e.fl, e.rd);
                end
            end
        end
    end

    task automatic fetch_chk(input logic [PW-1:0] pc, input logic [PW-1:0] npc,
                             input logic tk, input string req);
        exp_t e;
        #1;
        res_valid = 1'b0;
        fetch_pc  = pc;
        e = '{is_res: 1'b0, npc: npc, tk: tk, fl: 1'b0, rd: '0, chk_rd: 1'b0, req: req};
        sb.push_back(e);
        @(posedge clk);
    endtask

    task automatic resolve(input logic vld, input logic [PW-1:0] pc, input logic [PW-1:0] tgt,
                           input logic tk, input logic ptk, input logic [PW-1:0] ptgt,
                           input logic fl, input logic [PW-1:0] rd, input string req);
        exp_t e;
        #1;
        res_valid = vld; res_pc = pc; res_target = tgt; res_taken = tk;
        res_pred_taken = ptk; res_pred_target = ptgt;
        e = '{is_res: 1'b1, npc: '0, tk: 1'b0, fl: fl, rd: rd, chk_rd: fl, req: req};
        sb.push_back(e);
        @(posedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    localparam logic [PW-1:0] X = 32'h100;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        fetch_chk(X, X + 4, 1'b0, "R1 reset leaves table empty");
        fetch_chk(32'h2000, 32'h2004, 1'b0, "R2 miss gives pc+4");
        // first resolution of X: taken, predicted not taken
        resolve(1, X, 32'h200, 1, 0, X + 4, 1, 32'h200, "R8 direction mispredict");
        fetch_chk(X, 32'h200, 1'b1, "R4 allocated entry predicts taken");
        resolve(1, X, 32'h200, 1, 1, 32'h200, 0, '0, "R10 correct prediction no flush");
        resolve(1, X, 32'h200, 1, 1, 32'h200, 0, '0, "R10 correct prediction at top");
        resolve(1, X, 32'h200, 0, 1, 32'h200, 1, X + 4, "R8 not-taken redirect pc+4");
        fetch_chk(X, 32'h200, 1'b1, "R6 saturated high then one step down still taken");
        resolve(1, X, 32'h200, 0, 1, 32'h200, 1, X + 4, "R8 mispredict weak taken");
        fetch_chk(X, X + 4, 1'b0, "R3 hit in weak not-taken predicts pc+4");
        resolve(1, X, 32'h200, 0, 0, X + 4, 0, '0, "R10 correct not-taken");
        resolve(1, X, 32'h200, 0, 0, X + 4, 0, '0, "R10 correct not-taken at bottom");
        resolve(1, X, 32'h200, 1, 0, X + 4, 1, 32'h200, "R8 mispredict from bottom");
        fetch_chk(X, X + 4, 1'b0, "R6 saturated low then one step up still not taken");
        resolve(1, X, 32'h200, 1, 0, X + 4, 1, 32'h200, "R8 mispredict weak not-taken");
        fetch_chk(X, 32'h200, 1'b1, "R6 step up to weak taken");
        resolve(1, X, 32'h300, 1, 1, 32'h200, 1, 32'h300, "R9 target mismatch");
        fetch_chk(X, 32'h300, 1'b1, "R7 target replaced");
        resolve(0, X, 32'h900, 0, 1, 32'h200, 0, '0, "R10 no flush without res_valid");
        fetch_chk(X, 32'h300, 1'b1, "R10 invalid resolution leaves entry");
        resolve(1, 32'h400, 32'h800, 0, 0, 32'h404, 0, '0, "R5 not-taken miss no flush");
        resolve(1, 32'h440, 32'h880, 0, 0, 32'h444, 0, '0, "R5 second not-taken miss");
        fetch_chk(32'h400, 32'h404, 1'b0, "R5 not-taken miss not allocated");
        // fill slots 1..3, then wrap to slot 0
        for (int k = 1; k <= 3; k++) begin
            logic [PW-1:0] bp;
            bp = 32'h1000 * k;
            resolve(1, bp, bp + 32'h50, 1, 0, bp + 4, 1, bp + 32'h50, "R4 allocate");
        end
        fetch_chk(X, 32'h300, 1'b1, "R11 oldest survives while slots remain");
        resolve(1, 32'h5000, 32'h5050, 1, 0, 32'h5004, 1, 32'h5050, "R11 allocate past last slot");
        fetch_chk(X, X + 4, 1'b0, "R11 oldest entry evicted after wrap");
        fetch_chk(32'h1000, 32'h1050, 1'b1, "R11 slot 1 survives");
        fetch_chk(32'h3000, 32'h3050, 1'b1, "R11 slot 3 survives");
        fetch_chk(32'h5000, 32'h5050, 1'b1, "R11 new entry predicts");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule